// File: doc/BRIEF.md
# Fuse Array Auto-Read Controller

This block gives software read access to a 512-byte one-time-programmable fuse array through three 32-bit registers. To read one fuse word, software first loads a byte address and makes it active by raising and then lowering an address-latch strobe. It then raises and lowers a start bit. While the read runs, a busy flag is set. When busy clears, the result is taken from the read-data register.

The fuse array is modelled as a ROM with a fixed access latency of `RD_LAT` clocks, and its contents are computed from the byte index. A read is launched only while the power-down bit is clear and the auto-read enable bit is set. The parameter `WORD_BYTES` selects one of two modes. With value 1, each address picks one byte. With value 4, each address picks one 32-bit little-endian word, and addresses 0 to 127 are valid. A third register holds an encrypt-enable bit that is stored and read back only.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After reset the control register (offset 0x04) reads 0x0800_0000, which means power-down bit 27 = 1, enable bit 24 = 0 and busy bit 26 = 0. The data register (offset 0x08) reads 0.
- R2: The control field in bits 10:0 becomes the active read address only on a write that clears bit 11 while bit 11 was stored as 1. Writing the field without that high-then-low pulse leaves the active address unchanged.
- R3: A write that clears bit 25 while bit 25 was stored as 1 launches one read, provided the same write leaves bit 27 = 0 and bit 24 = 1 and no read is busy. Busy (bit 26) reads 1 from the cycle after that write for exactly `RD_LAT` cycles. The result is in the data register when busy reads 0, and the data register changes at no other time.
- R4: Fuse byte b (0..511) holds ((b*13 + 7) mod 256) XOR (0x80 if b ≥ 256, else 0). In word mode, word a is {byte 4a+3, byte 4a+2, byte 4a+1, byte 4a}.
- R5: In byte mode the data register holds the byte zero-extended to 32 bits. An address of 512 or more in byte mode, or of 128 or more in word mode, returns 0.
- R6: A start pulse given while power-down is 1 or enable is 0 is ignored: busy stays 0 and the data register keeps its value.
- R7: A start pulse given while busy is 1 is ignored, and an address-latch pulse during a read does not change the read in progress.
- R8: Bit 10 of offset 0x10 is stored and read back. All other bits of that register read 0.
- R9: Busy is read-only: writing 1 to bit 26 without a valid start pulse leaves busy at 0.
- R10: Offsets 0x00 and 0x0C read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |

## Verification
A register write takes effect at the clock edge that captures it, and the read path is combinational. Busy is therefore due to read 1 at the first falling edge after the launching write, and to stay 1 for `RD_LAT` falling edges. The fetched value is due at the falling edge where busy first reads 0. The bench drives on falling edges, samples one nanosecond later, and checks busy at each of those sampling points. It checks the data only at the falling edge where busy clears, for both the byte-mode and word-mode instances. Ignored pulses are checked at the next sampling point by reading busy and the data register.

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl #(
  parameter int WORD_BYTES = 4,
  parameter int RD_LAT     = 8,
  parameter int ARRAY_B    = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int CW     = $clog2(RD_LAT + 1);
  localparam int NWORDS = ARRAY_B / WORD_BYTES;

  logic [10:0]   addr_f, act_addr, rd_addr;
  logic          latch_q, start_q, ren, pd, busy, enc;
  logic [CW-1:0] cnt;
  logic [31:0]   data_q;

  function automatic logic [7:0] fbyte(input int b);
    logic [7:0] v;
    v = 8'((b * 13 + 7) % 256);
    if (b >= 256) v = v ^ 8'h80;
    return v;
  endfunction

  function automatic logic [31:0] fetch(input logic [10:0] a);
    int ai;
    ai = int'(a);
    if (ai >= NWORDS) return 32'h0;
    if (WORD_BYTES == 1) return {24'h0, fbyte(ai)};
    return {fbyte(4*ai+3), fbyte(4*ai+2), fbyte(4*ai+1), fbyte(4*ai)};
  endfunction

  wire ctrl_wr = reg_wr && reg_addr == 8'h04;
  wire launch  = ctrl_wr && start_q && !reg_wdata[25] && !reg_wdata[27]
                 && reg_wdata[24] && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_f <= '0; act_addr <= '0; rd_addr <= '0;
      latch_q <= 1'b0; start_q <= 1'b0; ren <= 1'b0; pd <= 1'b1;
      busy <= 1'b0; cnt <= '0; data_q <= '0; enc <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        addr_f  <= reg_wdata[10:0];
        latch_q <= reg_wdata[11];
        ren     <= reg_wdata[24];
        start_q <= reg_wdata[25];
        pd      <= reg_wdata[27];
        if (latch_q && !reg_wdata[11]) act_addr <= reg_wdata[10:0];
      end
      if (reg_wr && reg_addr == 8'h10) enc <= reg_wdata[10];
      if (busy) begin
        if (cnt == '0) begin
          busy   <= 1'b0;
          data_q <= fetch(rd_addr);
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (launch) begin
        busy    <= 1'b1;
        cnt     <= CW'(RD_LAT - 1);
        rd_addr <= act_addr;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      8'h04:   reg_rdata = {4'h0, pd, busy, start_q, ren, 12'h0, latch_q, addr_f};
      8'h08:   reg_rdata = data_q;
      8'h10:   reg_rdata = {21'h0, enc, 10'h0};
      default: reg_rdata = 32'h0;
    endcase
  end

  p_launch_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!pd && ren));
  p_data_on_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_q) |-> $fell(busy));
  p_busy_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> busy);
  p_rd_addr_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rd_addr));
  p_latch_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_addr) |-> $fell(latch_q));
endmodule

// File: tb/fuse_rd_ctrl_tb.sv
`timescale 1ns/1ps
module fuse_rd_ctrl_tb;
  localparam int LAT = 8;
  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, rd_w, rd_b;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fuse_rd_ctrl #(.WORD_BYTES(4), .RD_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rd_w));
  fuse_rd_ctrl #(.WORD_BYTES(1), .RD_LAT(LAT)) u_dut_byte (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rd_b));

  function automatic logic [7:0] fb(input int b);
    logic [7:0] v;
    v = 8'((b * 13 + 7) % 256);
    if (b >= 256) v ^= 8'h80;
    return v;
  endfunction
  function automatic logic [31:0] exp_w(input int a);
    if (a >= 128) return 0;
    return {fb(4*a+3), fb(4*a+2), fb(4*a+1), fb(4*a)};
  endfunction
  function automatic logic [31:0] exp_b(input int a);
    if (a >= 512) return 0;
    return {24'h0, fb(a)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] w, output logic [31:0] b);
    reg_addr = a; #1; w = rd_w; b = rd_b;
  endtask

  task automatic latch(input int a);
    wr(8'h04, 32'h0100_0800 | a);
    wr(8'h04, 32'h0100_0000 | a);
  endtask

  task automatic start(input logic [31:0] base);
    wr(8'h04, base | 32'h0200_0000);
    wr(8'h04, base);
  endtask

  task automatic wait_idle();
    logic [31:0] w, b;
    for (int i = 0; i < 40; i++) begin
      rd(8'h04, w, b);
      if (!w[26] && !b[26]) return;
      @(negedge clk);
    end
    chk("R3 busy never cleared", w[26], 0);
  endtask

  task automatic full_read(input int a, input bit timed);
    logic [31:0] w, b;
    latch(a);
    start(32'h0100_0000 | a);
    if (timed) begin
      for (int k = 0; k < LAT; k++) begin
        rd(8'h04, w, b);
        chk("R3 busy high", {w[26], b[26]}, 2'b11);
        @(negedge clk);
      end
      rd(8'h04, w, b);
      chk("R3 busy clear", {w[26], b[26]}, 2'b00);
    end else wait_idle();
    rd(8'h08, w, b);
    chk("R4 R5 word data", w, exp_w(a));
    chk("R4 R5 byte data", b, exp_b(a));
  endtask

  initial begin
    logic [31:0] w, b, pw, pb;
    void'($urandom(32'd7141));
    #9 rst_n = 1;
    @(negedge clk);
    rd(8'h04, w, b);
    chk("R1 ctrl reset", w, 32'h0800_0000);
    chk("R1 ctrl reset byte", b, 32'h0800_0000);
    rd(8'h08, w, b);
    chk("R1 data reset", w | b, 0);

    full_read(5, 1);
    full_read(0, 1);
    full_read(127, 0);
    full_read(128, 0);
    full_read(300, 0);
    full_read(511, 0);
    full_read(512, 0);
    full_read(2047, 0);

    latch(20);
    wr(8'h04, 32'h0100_0000 | 33);
    start(32'h0100_0000 | 33);
    wait_idle();
    rd(8'h08, w, b);
    chk("R2 unlatched address ignored", w, exp_w(20));
    chk("R2 unlatched address ignored byte", b, exp_b(20));

    rd(8'h08, pw, pb);
    start(32'h0900_0000);
    rd(8'h04, w, b);
    chk("R6 pd blocks busy", w[26], 0);
    start(32'h0000_0000);
    rd(8'h04, w, b);
    chk("R6 no enable blocks busy", b[26], 0);
    @(negedge clk); @(negedge clk);
    rd(8'h08, w, b);
    chk("R6 data kept", w, pw);
    chk("R6 data kept byte", b, pb);

    latch(9);
    start(32'h0100_0000 | 9);
    latch(60);
    start(32'h0100_0000 | 60);
    wait_idle();
    rd(8'h08, w, b);
    chk("R7 in-progress read kept", w, exp_w(9));
    chk("R7 in-progress read kept byte", b, exp_b(9));
    @(negedge clk);
    rd(8'h04, w, b);
    chk("R7 start during busy ignored", w[26], 0);

    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, w, b);
    chk("R8 encrypt bit set", w, 32'h0000_0400);
    wr(8'h10, 32'h0);
    rd(8'h10, w, b);
    chk("R8 encrypt bit clear", b, 0);

    wr(8'h04, 32'h0500_0000);
    rd(8'h04, w, b);
    chk("R9 busy read-only", w[26], 0);
    rd(8'h00, w, b);
    chk("R10 offset 0 zero", w | b, 0);
    rd(8'h0C, w, b);
    chk("R10 offset C zero", w | b, 0);

    for (int n = 0; n < 60; n++) begin
      int a;
      a = ($urandom % 2) ? int'($urandom % 140) : int'($urandom % 600);
      full_read(a, (n % 10) == 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule